// File: doc/BRIEF.md
# I2C Slave Receive Engine with Clock Stretching

This block is the receive half of an I2C target inside a register-mapped peripheral. It watches the synchronized SCL and SDA lines for a START. It shifts in the first byte after the START and compares its upper seven bits with a programmed own address. If they match and the direction bit is a write, the block accepts each following byte into a data register and raises a full flag. It acknowledges every byte with a level set by software. Bus outputs are pull-low enables, one for SCL and one for SDA, meant for open-drain pads.

The host reads the data register with a one-cycle read strobe, and that read sets the pace of reception. If the host has not yet read the previous byte when a new byte completes, the engine holds SCL low after the 8th falling clock edge. Once the read happens, it moves the waiting byte across, acknowledges it and releases the clock. The address byte itself is placed in the data register and raises the full flag, so the host must consume it with a dummy read.

The state machine has five states. ST_IDLE waits for a START. ST_SHIFT samples bits on SCL rising edges, MSB first. ST_HOLD stretches SCL while the previous byte is unread. ST_ACK drives the acknowledge during the 9th clock. ST_IGNORE parks the engine after a foreign address or a read request.

The transitions are:
- START, from any state: go to ST_SHIFT.
- STOP or disable: go to ST_IDLE.
- ST_SHIFT, on the 8th falling edge:
  - mismatched or read address: go to ST_IGNORE.
  - register still full: go to ST_HOLD.
  - register free: load the byte and go to ST_ACK.
- ST_HOLD, once the register is empty: load the byte and go to ST_ACK.
- ST_ACK, on the 9th falling edge: go to ST_SHIFT for the next data byte.

Top module: `i2c_srx_engine`

## Requirements
- R1: After reset, and one cycle after `en` goes low, `scl_pull` and `sda_pull` are 0. After reset `rx_full` and `stop_seen` are 0. While `en` is low, bus activity is ignored.
- R2: The first byte after a START (SDA falling while SCL is high) is sampled on SCL rising edges, MSB first. It is addressed to the block when bits 7..1 equal `own_addr` and bit 0 (the direction bit) is 0.
- R3: If the address byte does not match, or bit 0 is 1, the block gives no acknowledge, pulls nothing and loads nothing. It ignores all bytes until the next START.
- R4: A matching address byte is loaded into `rx_data` as sent, address and direction bit together, and `rx_full` is set.
- R5: Every data byte after a matching address is loaded into `rx_data` and sets `rx_full`.
- R6: During the 9th clock of an accepted byte, SDA is pulled low when the acknowledge level captured for that byte is 0 (ACK). It is left released when that level is 1 (NACK).
- R7: The acknowledge level for a byte is `ack_level` as it stands when the byte is loaded into `rx_data`. A later change applies only to following bytes.
- R8: `rd_strobe` with `rx_full` set clears `rx_full` on the next cycle. A strobe while `rx_full` is 0 changes neither `rx_full` nor `rx_data`.
- R9: If a byte completes (8th falling SCL edge) while `rx_full` is 1, SCL is held low and `rx_data` keeps the unread byte. After the read, the new byte is loaded, `rx_full` is set and SCL is released, so no byte is lost.
- R10: A STOP (SDA rising while SCL is high) returns the block to idle with both pulls released and sets `stop_seen`. The next START clears `stop_seen`.
- R11: A repeated START in the middle of a transfer restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable |
| own_addr | input | ADDR_W | Programmed 7-bit own address |
| ack_level | input | 1 | Acknowledge level to send: 0 = ACK, 1 = NACK |
| scl_in | input | 1 | SCL line as seen at the pad |
| sda_in | input | 1 | SDA line as seen at the pad |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| rd_strobe | input | 1 | One-cycle read of the data register |
| rx_data | output | DATA_W | Received byte |
| rx_full | output | 1 | Data register holds an unread byte |
| stop_seen | output | 1 | STOP observed since the last START |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Stretch while full.** A second byte completes while the first is unread. A design that did not stretch would overwrite the unread byte or acknowledge a byte it never stored, and the bench would see the wrong `rx_data` after the read.
- **Late `ack_level` change.** The bench flips `ack_level` during the 9th clock high phase. A design that drives SDA straight from the input would send the wrong acknowledge on that byte.
- **Foreign address and read direction.** These must leave `rx_full` clear for every later byte until the next START. A design that fell back to shifting would then acknowledge stray data.
- **Repeated START and reads while empty.** A repeated START must re-enter the address phase. A read strobe on an empty register must leave both the flag and the data alone.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_HOLD,
        ST_ACK,
        ST_IGNORE
    } srx_state_e;

endpackage

// File: rtl/i2c_srx_sync.sv
// Multi-line synchronizer with one extra history stage for edge detection.
module i2c_srx_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] cur,
    output logic [LINES-1:0] prev
);

    // pipe[0] is the first flop; pipe[STAGES-1] is the synchronized value,
    // pipe[STAGES] the value one cycle earlier.
    logic [STAGES:0][LINES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-1:0], raw};
        end
    end

    assign cur  = pipe[STAGES-1];
    assign prev = pipe[STAGES];

endmodule

// File: rtl/i2c_srx_shifter.sv
// Serial-in shift register with bit counter, MSB first.
module i2c_srx_shifter #(
    parameter  int W  = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [W-1:0]  word,
    output logic [CW-1:0] count,
    output logic          done
);

    localparam logic [CW-1:0] FULL_COUNT = CW'(W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            count <= '0;
        end else if (clr) begin
            word  <= '0;
            count <= '0;
        end else if (shift_en && (count != FULL_COUNT)) begin
            word  <= {word[W-2:0], bit_in};
            count <= count + 1'b1;
        end
    end

    assign done = (count == FULL_COUNT);

endmodule

// File: rtl/i2c_srx_rxbuf.sv
// Receive data register with full flag.
module i2c_srx_rxbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         rd,
    output logic [W-1:0] dout,
    output logic         full
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
            full <= 1'b0;
        end else if (load) begin
            dout <= din;
            full <= 1'b1;
        end else if (rd) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_srx_engine.sv
module i2c_srx_engine
    import i2c_srx_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_level,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              stop_seen
);

    localparam int CW = $clog2(DATA_W + 1);

    // ---------------- line synchronization and bus events ----------------
    logic scl_s, sda_s, scl_q, sda_q;

    i2c_srx_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({scl_in, sda_in}),
        .cur   ({scl_s, sda_s}),
        .prev  ({scl_q, sda_q})
    );

    logic scl_rise, scl_fall, start_ev, stop_ev;

    always_comb begin
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
        start_ev = scl_s & scl_q & sda_q & ~sda_s;
        stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
    end

    // ---------------- datapath ----------------
    srx_state_e        state, nxt;
    logic              shift_clr, shift_en, byte_done;
    logic [DATA_W-1:0] shift_word;
    logic [CW-1:0]     shift_count;
    logic              load_byte;
    logic              addr_phase;
    logic              ack_lat;
    logic              addr_ok;
    logic              enter_frame, next_frame;

    i2c_srx_shifter #(
        .W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (shift_clr),
        .shift_en (shift_en),
        .bit_in   (sda_s),
        .word     (shift_word),
        .count    (shift_count),
        .done     (byte_done)
    );

    i2c_srx_rxbuf #(
        .W (DATA_W)
    ) u_rxbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_byte),
        .din   (shift_word),
        .rd    (rd_strobe),
        .dout  (rx_data),
        .full  (rx_full)
    );

    assign addr_ok  = (shift_word[DATA_W-1 -: ADDR_W] == own_addr) && !shift_word[0];
    assign shift_en = (state == ST_SHIFT) && scl_rise;

    // ---------------- next-state logic ----------------
    always_comb begin
        nxt         = state;
        load_byte   = 1'b0;
        shift_clr   = 1'b0;
        enter_frame = 1'b0;
        next_frame  = 1'b0;
        if (!en) begin
            nxt       = ST_IDLE;
            shift_clr = 1'b1;
        end else if (start_ev) begin
            nxt         = ST_SHIFT;
            shift_clr   = 1'b1;
            enter_frame = 1'b1;
        end else if (stop_ev) begin
            nxt       = ST_IDLE;
            shift_clr = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    nxt = ST_IDLE;
                end
                ST_SHIFT: begin
                    if (scl_fall && byte_done) begin
                        if (addr_phase && !addr_ok) begin
                            nxt = ST_IGNORE;
                        end else if (rx_full) begin
                            nxt = ST_HOLD;
                        end else begin
                            load_byte = 1'b1;
                            nxt       = ST_ACK;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!rx_full) begin
                        load_byte = 1'b1;
                        nxt       = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        shift_clr  = 1'b1;
                        next_frame = 1'b1;
                        nxt        = ST_SHIFT;
                    end
                end
                ST_IGNORE: begin
                    nxt = ST_IGNORE;
                end
                default: begin
                    nxt = ST_IDLE;
                end
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // ---------------- frame bookkeeping ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_phase <= 1'b0;
            ack_lat    <= 1'b1;
            stop_seen  <= 1'b0;
        end else begin
            if (enter_frame) begin
                addr_phase <= 1'b1;
            end else if (next_frame) begin
                addr_phase <= 1'b0;
            end
            if (load_byte) begin
                ack_lat <= ack_level;
            end
            if (en && start_ev) begin
                stop_seen <= 1'b0;
            end else if (en && stop_ev) begin
                stop_seen <= 1'b1;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        scl_pull = (state == ST_HOLD);
        sda_pull = (state == ST_ACK) && !ack_lat;
    end

endmodule

// File: rtl/i2c_srx_checker.sv
module i2c_srx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              scl_pull,
    input logic              sda_pull,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              stop_seen
);

    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_pull && !sda_pull)); // R1

    AST_ACK_WITH_LOADED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> rx_full); // R5

    AST_SINGLE_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_pull && sda_pull)); // R6

    AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rd_strobe) |=> !rx_full); // R8

    AST_STRETCH_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> $past(rx_full)); // R9

    AST_UNREAD_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_strobe) |=> (rx_full && $stable(rx_data))); // R9

    AST_STOP_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_seen) |-> (!scl_pull && !sda_pull)); // R10

endmodule

bind i2c_srx_engine i2c_srx_checker #(
    .DATA_W (DATA_W)
) u_srx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .rd_strobe (rd_strobe),
    .rx_data   (rx_data),
    .rx_full   (rx_full),
    .stop_seen (stop_seen)
);

// File: tb/i2c_srx_engine_bench.sv
`timescale 1ns/1ps
module i2c_srx_engine_bench;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [6:0] own_addr = 7'h2A;
    logic       ack_level = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       scl_pull, sda_pull, rx_full, stop_seen;
    logic [7:0] rx_data;
    wire        scl_line = scl_m & ~scl_pull;
    wire        sda_line = sda_m & ~sda_pull;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    i2c_srx_engine u_i2c_srx_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .own_addr  (own_addr),
        .ack_level (ack_level),
        .scl_in    (scl_line),
        .sda_in    (sda_line),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .rd_strobe (rd_strobe),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .stop_seen (stop_seen)
    );

    // ---------------- reference functions ----------------
    function automatic bit addr_hit(input logic [7:0] ab, input logic [6:0] own);
        return (ab[7:1] == own) && !ab[0];
    endfunction

    function automatic logic ack_expected(input logic lvl);
        return (lvl == 1'b0);
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b;
        tick(Q);
        scl_m = 1'b1;
        wait_scl_high();
        tick(Q);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic ack_phase(input bit flip, output logic got);
        sda_m = 1'b1;
        tick(Q);
        scl_m = 1'b1;
        wait_scl_high();
        if (flip) ack_level = ~ack_level;
        tick(Q);
        got = !sda_line;
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit flip, output logic got);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        ack_phase(flip, got);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        tick(Q);
        scl_m = 1'b1;
        wait_scl_high();
        tick(Q);
        sda_m = 1'b0;
        tick(Q);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        tick(Q);
        scl_m = 1'b1;
        wait_scl_high();
        tick(Q);
        sda_m = 1'b1;
        tick(Q);
    endtask

    task automatic host_read(output logic [7:0] d);
        d = rx_data;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic       got;
        logic [7:0] d;
        int         seed_out;
        seed_out = $urandom(32'h1C5A);

        tick(5);
        // R1: reset state
        check("R1 scl_pull reset", 32'(scl_pull), 0);
        check("R1 sda_pull reset", 32'(sda_pull), 0);
        check("R1 rx_full reset", 32'(rx_full), 0);
        check("R1 stop_seen reset", 32'(stop_seen), 0);
        rst_n = 1'b1;
        tick(5);

        // R1: disabled block ignores a matching transfer
        bus_start();
        send_byte({7'h2A, 1'b0}, 1'b0, got);
        check("R1 no ack while disabled", 32'(got), 0);
        check("R1 no load while disabled", 32'(rx_full), 0);
        bus_stop();
        en = 1'b1;
        tick(5);

        // R2 R4: address match, address byte lands in data register
        ack_level = 1'b0;
        bus_start();
        check("R10 stop_seen clear after start", 32'(stop_seen), 0);
        send_byte({7'h2A, 1'b0}, 1'b0, got);
        check("R2 address ack", 32'(got), 1);
        check("R4 full after address", 32'(rx_full), 1);
        check("R4 address byte in data", 32'(rx_data), 32'h54);
        host_read(d);
        check("R8 read clears full", 32'(rx_full), 0);
        // R5: data byte
        send_byte(8'hA5, 1'b0, got);
        check("R5 data ack", 32'(got), 1);
        check("R5 full after data", 32'(rx_full), 1);
        check("R5 data value", 32'(rx_data), 32'hA5);
        host_read(d);
        // R8: read while empty has no effect
        host_read(d);
        check("R8 empty read keeps full low", 32'(rx_full), 0);
        check("R8 empty read keeps data", 32'(rx_data), 32'hA5);

        // R7: change during ack applies only to next byte
        ack_level = 1'b0;
        send_byte(8'h3C, 1'b1, got);
        check("R7 current ack keeps old level", 32'(got), 1);
        host_read(d);
        send_byte(8'hC3, 1'b0, got);
        check("R6 nack for level 1", 32'(got), 0);
        check("R7 next byte uses new level", 32'(rx_data), 32'hC3);
        host_read(d);
        ack_level = 1'b0;

        // R9: stretch while previous byte unread
        send_byte(8'h81, 1'b0, got);
        fork
            send_byte(8'h7E, 1'b0, got);
            begin
                for (int k = 0; k < 3000 && !scl_pull; k++) @(negedge clk);
                tick(50);
                check("R9 scl held low", 32'(scl_pull), 1);
                check("R9 unread byte kept", 32'(rx_data), 32'h81);
                host_read(d);
                check("R9 first byte read", 32'(d), 32'h81);
            end
        join
        check("R9 held byte acked", 32'(got), 1);
        check("R9 held byte loaded", 32'(rx_data), 32'h7E);
        check("R9 full after release", 32'(rx_full), 1);
        check("R9 scl released", 32'(scl_pull), 0);
        host_read(d);

        // R10: stop
        bus_stop();
        tick(5);
        check("R10 stop_seen set", 32'(stop_seen), 1);
        check("R10 pulls released", 32'({scl_pull, sda_pull}), 0);

        // R3: mismatch, then data is ignored
        bus_start();
        check("R10 stop_seen cleared by start", 32'(stop_seen), 0);
        send_byte({7'h2B, 1'b0}, 1'b0, got);
        check("R3 no ack on mismatch", 32'(got), 0);
        send_byte(8'h00, 1'b0, got);
        check("R3 data ignored", 32'(got), 0);
        check("R3 no load", 32'(rx_full), 0);
        bus_stop();
        // R3: read direction ignored
        bus_start();
        send_byte({7'h2A, 1'b1}, 1'b0, got);
        check("R3 no ack on read direction", 32'(got), 0);
        check("R3 no load on read direction", 32'(rx_full), 0);
        bus_stop();

        // R11: repeated start
        bus_start();
        send_byte({7'h2A, 1'b0}, 1'b0, got);
        host_read(d);
        send_byte(8'h11, 1'b0, got);
        host_read(d);
        bus_start();
        send_byte({7'h2A, 1'b0}, 1'b0, got);
        check("R11 address re-acked", 32'(got), 1);
        check("R11 address reloaded", 32'(rx_data), 32'h54);
        host_read(d);
        bus_stop();

        // Random transactions (R2 R3 R5 R6)
        for (int t = 0; t < 20; t++) begin
            logic [7:0] ab;
            logic [7:0] db;
            logic       lvl;
            bit         hit;
            int         nb;
            own_addr = 7'($urandom_range(0, 127));
            ab = ($urandom_range(0, 1) != 0) ? {own_addr, 1'b0} : 8'($urandom);
            hit = addr_hit(ab, own_addr);
            nb = $urandom_range(1, 4);
            lvl = 1'($urandom);
            ack_level = lvl;
            bus_start();
            send_byte(ab, 1'b0, got);
            check("R2 random address ack", 32'(got), hit ? 32'(ack_expected(lvl)) : 0);
            check("R3 random address full", 32'(rx_full), hit ? 1 : 0);
            if (rx_full) host_read(d);
            for (int b = 0; b < nb; b++) begin
                db = 8'($urandom);
                lvl = 1'($urandom);
                ack_level = lvl;
                send_byte(db, 1'b0, got);
                check("R6 random data ack", 32'(got), hit ? 32'(ack_expected(lvl)) : 0);
                if (hit) check("R5 random data value", 32'(rx_data), 32'(db));
                check("R5 random data full", 32'(rx_full), hit ? 1 : 0);
                if (rx_full) host_read(d);
            end
            bus_stop();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule